// File: doc/BRIEF.md
# Multi-Pass Serial Insertion Sorter

This block sorts an array of M words with one short insertion chain of N cells. Words are first written one per cycle into an input buffer through a serial load port. After a start pulse, the block streams the whole array through the chain. Each cell keeps the larger of its contents and the arriving word, and passes the smaller one to the next cell. Words pushed out of the last cell are unsorted leftovers. They are kept in a recirculation buffer.

When a pass ends, the chain holds the N largest words that remained. These are latched into a snapshot bank and copied through a mux into output memory, one word per cycle. At the same time the leftovers of that pass are streamed back through the chain, which is emptied on the first word of the new pass. The recirculation buffer has two banks that swap roles on every pass. One bank is read while the other collects the new leftovers.

The run ends once every block of N has been written. Output memory then holds the array in descending order. A caller reads it through a combinational read port.

Top module: `isort_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy` and `done` are both 0.
- R2: Inside the chain, occupied cells always form a prefix, and their values never increase from cell 0 toward cell N-1.
- R3: While idle, each cycle with `load_valid` high writes `load_data` into the next input buffer slot. Slots run 0 to M-1 and wrap back to 0. A start pulse sorts the M words held in the buffer.
- R4: Pass k (k = 1..M/N) streams M-(k-1)*N words, one per cycle. The chain is full at the end of every pass. A word leaves the last cell exactly on the pass cycles whose in-pass index is N or higher. These words are the ones the next pass streams.
- R5: After a run, output address a (0..M-1) holds the a-th largest input word. The result is nonincreasing from address 0 upward and is a permutation of the input. Pass k fills addresses (k-1)*N to k*N-1.
- R6: `done` first goes high exactly N*P*(P+1)/2 + N clock edges after the edge that samples `start`, where P = M/N. This is 88 edges for M=32 and N=8. M must be a multiple of N.
- R7: `done` is high for exactly one cycle, and `busy` is low during that cycle and after it.
- R8: While busy, a `start` pulse and `load_valid` are both ignored. The run keeps its timing, and the input buffer keeps its contents.
- R9: Equal input words, including the extremes 0 and 0xFFFF, are all kept in the result.
- R10: A second run started right after a first one gives the correct result. Nothing carries over from the earlier run's chain or recirculation contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to sort the buffered array |
| load_valid | input | 1 | Write `load_data` into the input buffer (only while idle) |
| load_data | input | 16 | Serial input word |
| rd_addr | input | $clog2(M) | Output memory read address |
| rd_data | output | 16 | Output memory word at `rd_addr` |
| busy | output | 1 | A sort run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Assertions check four things on every cycle:
- the chain stays a descending prefix of occupied cells;
- each snapshot is taken from a full chain;
- the words written into output memory never increase within a block;
- the overflow schedule matches the in-pass word index.

Two timing points are also checked on every cycle: the edge count from start to done equals the derived latency, and the done pulse lasts one cycle. Only the bench's scenarios can show that the final memory is the correct sorted permutation. The same holds for keeping duplicates and extreme values, and for a restart leaving no stale state. They also show that start and load requests made mid-run change neither the timing nor the buffered data.

// File: rtl/isort_pkg.sv
package isort_pkg;
    parameter int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  occ;
        word_t val;
    } cell_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } phase_t;

    // Edges from the start edge to the done edge: every pass streams its
    // words back to back, and only the last block dump is not hidden.
    function automatic int unsigned sort_latency(int unsigned m, int unsigned n);
        int unsigned p;
        p = m / n;
        return n * p * (p + 1) / 2 + n;
    endfunction

    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction
endpackage

// File: rtl/isort_chain.sv
module isort_chain
    import isort_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  word_t            in_word,
    input  logic             clear,
    output cell_t [N-1:0]    cells_nxt,
    output logic             ovf_vld,
    output word_t            ovf_word
);
    cell_t [N-1:0] cur_q;
    logic          cv [N+1];
    word_t         cd [N+1];

    // Ripple insertion: the word settles through all N cells in one cycle.
    always_comb begin
        cell_t eff;
        cv[0] = in_vld;
        cd[0] = in_word;
        for (int i = 0; i < N; i++) begin
            eff = cur_q[i];
            if (clear) eff.occ = 1'b0;
            cells_nxt[i] = eff;
            cv[i+1]      = 1'b0;
            cd[i+1]      = cd[i];
            if (cv[i]) begin
                if (!eff.occ) begin
                    cells_nxt[i] = '{occ: 1'b1, val: cd[i]};
                end else if (cd[i] > eff.val) begin
                    cells_nxt[i] = '{occ: 1'b1, val: cd[i]};
                    cv[i+1]      = 1'b1;
                    cd[i+1]      = eff.val;
                end else begin
                    cv[i+1]      = 1'b1;
                    cd[i+1]      = cd[i];
                end
            end
        end
    end

    assign ovf_vld  = cv[N];
    assign ovf_word = cd[N];

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= cells_nxt;
    end

    for (genvar g = 0; g < N - 1; g++) begin : g_ord
        // R2
        chain_order_chk: assert property (@(posedge clk) disable iff (rst)
            cur_q[g+1].occ |-> (cur_q[g].occ && (cur_q[g].val >= cur_q[g+1].val)));
    end
endmodule

// File: rtl/isort_dump.sv
module isort_dump
    import isort_pkg::*;
#(
    parameter int M = 32,
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  cell_t [N-1:0]         cells_in,
    input  logic [$clog2(M)-1:0]  base,
    input  logic [$clog2(M)-1:0]  rd_addr,
    output word_t                 rd_data,
    output logic                  last_wr
);
    localparam int AW = $clog2(M);
    localparam int CW = bits_for(N);

    word_t          snap [N];
    word_t          mem  [M];
    logic [AW-1:0]  base_q;
    logic [CW-1:0]  cnt;
    logic           act;
    logic [AW-1:0]  wr_addr;
    word_t          wr_word;
    logic [N-1:0]   occ_in;

    assign wr_addr = base_q + AW'(cnt);
    assign wr_word = snap[cnt];
    assign last_wr = act && (cnt == CW'(N - 1));
    assign rd_data = mem[rd_addr];

    always_comb begin
        for (int i = 0; i < N; i++) occ_in[i] = cells_in[i].occ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            act <= 1'b1;
            cnt <= '0;
        end else if (act) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(N - 1)) act <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            base_q <= base;
            for (int i = 0; i < N; i++) snap[i] <= cells_in[i].val;
        end
        if (act) mem[wr_addr] <= wr_word;
    end

    // R4
    full_snap_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (&occ_in));

    // R5
    dump_desc_chk: assert property (@(posedge clk) disable iff (rst)
        (act && cnt != '0) |-> (wr_word <= $past(wr_word)));
endmodule

// File: rtl/isort_top.sv
module isort_top
    import isort_pkg::*;
#(
    parameter int M = 32,
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  load_valid,
    input  logic [15:0]           load_data,
    input  logic [$clog2(M)-1:0]  rd_addr,
    output logic [15:0]           rd_data,
    output logic                  busy,
    output logic                  done
);
    localparam int P   = M / N;
    localparam int AW  = $clog2(M);
    localparam int PW  = bits_for(P);
    localparam int RD  = (M > N) ? M - N : 1;
    localparam int RW  = bits_for(RD);
    localparam int unsigned LAT = sort_latency(M, N);

    phase_t         phase;
    logic [PW-1:0]  pass_q;
    logic [AW-1:0]  word_idx;
    logic [AW-1:0]  load_ptr;

    word_t          inbuf [M];
    word_t          rbank [2][RD];

    logic           run;
    logic           last_in_pass;
    logic           rb_rd, rb_wr;
    logic [RW-1:0]  ovf_addr;
    word_t          src;

    cell_t [N-1:0]  cells_nxt;
    logic           ovf_vld;
    word_t          ovf_word;
    logic           last_wr;
    word_t          rd_word;

    assign run          = (phase == ST_RUN);
    assign busy         = (phase != ST_IDLE);
    assign last_in_pass = (32'(word_idx) == 32'(M - 1) - 32'(pass_q) * 32'(N));
    assign rb_wr        = pass_q[0];
    assign rb_rd        = ~pass_q[0];
    assign ovf_addr     = RW'(32'(word_idx) - 32'(N));
    assign src          = (pass_q == '0) ? inbuf[word_idx] : rbank[rb_rd][RW'(word_idx)];
    assign rd_data      = rd_word;

    isort_chain #(.N(N)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (run),
        .in_word   (src),
        .clear     (run && word_idx == '0),
        .cells_nxt (cells_nxt),
        .ovf_vld   (ovf_vld),
        .ovf_word  (ovf_word)
    );

    isort_dump #(.M(M), .N(N)) u_dump (
        .clk      (clk),
        .rst      (rst),
        .load     (run && last_in_pass),
        .cells_in (cells_nxt),
        .base     (AW'(32'(pass_q) * 32'(N))),
        .rd_addr  (rd_addr),
        .rd_data  (rd_word),
        .last_wr  (last_wr)
    );

    // Buffers carry no reset: their contents are only read after being written.
    always_ff @(posedge clk) begin
        if (phase == ST_IDLE && load_valid) inbuf[load_ptr] <= load_data;
        if (run && ovf_vld) rbank[rb_wr][ovf_addr] <= ovf_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            pass_q   <= '0;
            word_idx <= '0;
            load_ptr <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                ST_IDLE: begin
                    if (load_valid)
                        load_ptr <= (load_ptr == AW'(M - 1)) ? '0 : load_ptr + 1'b1;
                    if (start) begin
                        phase    <= ST_RUN;
                        pass_q   <= '0;
                        word_idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (last_in_pass) begin
                        word_idx <= '0;
                        if (pass_q == PW'(P - 1)) phase  <= ST_DRAIN;
                        else                      pass_q <= pass_q + 1'b1;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (last_wr) begin
                        phase <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    // Edge counter used only by the latency check.
    logic [31:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst || phase == ST_IDLE) cyc_q <= '0;
        else                         cyc_q <= cyc_q + 1'b1;
    end

    // R4
    ovf_sched_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_vld == (run && (32'(word_idx) >= 32'(N))));

    // R6
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc_q == 32'(LAT)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    start_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (run && start && !last_in_pass) |=> (word_idx == $past(word_idx) + 1'b1));
endmodule

// File: tb/tb_isort_top.sv
module tb_isort_top;
    localparam int M   = 32;
    localparam int N   = 8;
    localparam int P   = M / N;
    localparam int LAT = N * P * (P + 1) / 2 + N;
    localparam int AW  = $clog2(M);

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] seed;
    } pat_t;

    localparam int NPAT = 5;
    localparam pat_t [NPAT-1:0] PATS = '{
        '{3'd4, 16'd0},
        '{3'd3, 16'd0},
        '{3'd2, 16'hA5C3},
        '{3'd1, 16'd0},
        '{3'd0, 16'd5}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           load_valid = 1'b0;
    logic [15:0]    load_data = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [15:0]    rd_data;
    logic           busy;
    logic           done;

    int checks = 0;
    int fails  = 0;

    logic [15:0] cur  [M];
    logic [15:0] refs [M];

    isort_top #(.M(M), .N(N)) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_valid (load_valid),
        .load_data  (load_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [15:0] gen(input logic [2:0] mode, input logic [15:0] seed,
                                        input int i);
        logic [15:0] x;
        case (mode)
            3'd0: gen = seed + 16'(i * 37);
            3'd1: gen = 16'hFF00 - 16'(i * 101);
            3'd2: begin
                x   = 16'(i * 16'h9E37) ^ seed;
                x   = x ^ (x >> 5);
                gen = x ^ 16'(x << 3);
            end
            3'd3: gen = 16'((i % 3) * 16'h5555);
            default: gen = (i % 4 == 0) ? 16'hFFFF : (i % 4 == 1) ? 16'h0000 : 16'(i);
        endcase
    endfunction

    task automatic make_ref();
        logic [15:0] t;
        for (int i = 0; i < M; i++) refs[i] = cur[i];
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M - 1 - i; j++)
                if (refs[j] < refs[j+1]) begin
                    t = refs[j]; refs[j] = refs[j+1]; refs[j+1] = t;
                end
    endtask

    task automatic load_set();
        for (int i = 0; i < M; i++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_data  = cur[i];
        end
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic run_sort(input bit inject, input string req, output int lat);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start      = inject && (lat == 20);
            load_valid = inject && (lat == 30);
            load_data  = 16'hFFFF;
        end
        load_valid = 1'b0;
        start      = 1'b0;
        chk(lat == LAT, req, "latency", lat, LAT);
        @(posedge clk);
        @(negedge clk);
        // R7: done lasts one cycle and busy stays low
        chk(!done && !busy, "R7", "done/busy after pulse", {done, busy}, 0);
    endtask

    task automatic compare(input string req);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int a = 0; a < M; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            #1;
            if (rd_data !== refs[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (bad != 0) begin
            rd_addr = AW'(first);
            #1;
            chk(1'b0, req, $sformatf("memory word at %0d", first), int'(rd_data),
                int'(refs[first]));
        end else begin
            chk(1'b1, req, "memory", 0, 0);
        end
    endtask

    initial begin
        int lat;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1", "state after reset", {busy, done}, 0);

        // Table walk: R3 load, R4 multi-pass, R5 order, R6 latency, R9 duplicates
        for (int p = 0; p < NPAT; p++) begin
            for (int i = 0; i < M; i++) cur[i] = gen(PATS[p].mode, PATS[p].seed, i);
            make_ref();
            load_set();
            run_sort(1'b0, "R6", lat);
            case (PATS[p].mode)
                3'd0: compare("R4");
                3'd3: compare("R9");
                3'd4: compare("R9");
                3'd2: compare("R3");
                default: compare("R5");
            endcase
        end

        // R8: start and load requests while busy are ignored
        for (int i = 0; i < M; i++) cur[i] = gen(3'd2, 16'h1234, i) & 16'h7FFF;
        make_ref();
        load_set();
        run_sort(1'b1, "R8", lat);
        compare("R8");

        // R10: restart without reloading, buffer untouched by R8 injection
        run_sort(1'b0, "R10", lat);
        compare("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule